// File: doc/BRIEF.md
# Bounding-Box Tile Owner Distributor

This block sits between geometry processing and four raster units. It takes screen-space triangles one at a time in issue order. Each triangle arrives with three signed pixel positions and a sequence tag. The screen is cut into fixed tiles of 4 pixels across by 2 pixels down, and a static interleaved map gives each tile to exactly one raster unit.

For every triangle the block forms the axis-aligned bounding rectangle, clips it to the screen and lists the tiles it spans. It then writes an unchanged copy of the triangle, tag included, into the output queue of each raster unit that owns at least one of those tiles. A triangle that lies wholly off screen is consumed and produces no copy. Each raster unit can use the tag to put its arrivals back into issue order.

Both edges use valid/ready. An input triangle is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` depends on the triangle being presented: it is low while any queue that this triangle needs is full, so every copy is written in the same cycle or none is. On each output a copy leaves on a cycle where `out_valid[u]` and `out_ready[u]` are both high. While `out_valid[u]` is high and `out_ready[u]` is low, the copy is held unchanged. Each output drains on its own, independently of the others.

Top module: `tri_tile_distributor`

## Requirements
- R1: The bounding box is the per-axis minimum and maximum of the three vertices. A pixel (x, y) lies in tile (tx, ty) = (floor(x/4), floor(y/2)).
- R2: Tile (tx, ty) belongs to unit number (tx[0] XOR ty[0]) + 2*ty[1], where unit u drives bit u of the output vectors.
- R3: A copy goes to every unit that owns at least one tile inside the clipped box, and to no other unit.
- R4: A triangle is wholly off screen when its maximum x or y is below 0, its minimum x is above SCREEN_W-1, or its minimum y is above SCREEN_H-1. Such a triangle is accepted at once, even when queues are full, and yields no copy.
- R5: A box that reaches past the screen edge is clipped to pixels 0..SCREEN_W-1 and 0..SCREEN_H-1 before its tiles are derived.
- R6: While any queue selected by the presented triangle is full, `in_ready` is low and no queue is written.
- R7: Each copy carries the input unchanged, packed as {seq, x0, y0, x1, y1, x2, y2} with seq in the top bits. Copies leave each queue in acceptance order.
- R8: While `out_valid[u]` is high and `out_ready[u]` is low, `out_valid[u]` stays high and `out_tri[u]` stays stable.
- R9: After reset all queues are empty (`out_valid` is 0) and `in_ready` is high.
- R10: A box spanning four or more tiles both across and down reaches all four units.
- R11: A triangle only a few pixels in size that straddles a tile edge goes to both owners of the tiles on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input triangle present |
| in_ready | output | 1 | Input triangle can be taken this cycle |
| in_seq | input | SEQ_W | Issue-order tag |
| in_x0 | input | COORD_W | Vertex 0 x, signed pixels |
| in_y0 | input | COORD_W | Vertex 0 y, signed pixels |
| in_x1 | input | COORD_W | Vertex 1 x |
| in_y1 | input | COORD_W | Vertex 1 y |
| in_x2 | input | COORD_W | Vertex 2 x |
| in_y2 | input | COORD_W | Vertex 2 y |
| out_valid | output | 4 | Per-unit copy present |
| out_ready | input | 4 | Per-unit consumer ready |
| out_tri | output | 4 x (SEQ_W+6*COORD_W) | Per-unit packed triangle copy |

## Verification
The bench aims at three kinds of triangle. The first is a tiny triangle that straddles a vertical or a horizontal tile edge. A wrong tile size or a wrong ownership formula sends it to one unit or to the wrong pair. The second is a triangle that spans far beyond the screen on one side, or lies wholly outside it. Missing clipping would let negative or oversized tile indices select extra units, and a missing off-screen test would leak copies. The third is a triangle that needs a full queue. It presents that triangle while the queues are blocked and confirms that `in_ready` drops and that the empty queues receive nothing. A non-atomic design would show a partial copy there. It also confirms that a held output does not change. Randomised triangles, with random readiness on each output, are checked against a tile-by-tile reference for per-queue order and for the packed content.

// File: rtl/tri_dist_pkg.sv
package tri_dist_pkg;
  localparam int NUM_UNITS = 4;
  localparam int TILE_W_LOG = 2;  // 4 pixels across
  localparam int TILE_H_LOG = 1;  // 2 pixels down

  // interleaved ownership: neighbouring tiles differ in owner
  function automatic logic [1:0] tile_owner(input logic tx_lsb, input logic ty_b0,
                                            input logic ty_b1);
    return {ty_b1, tx_lsb ^ ty_b0};
  endfunction
endpackage

// File: rtl/tri_bbox.sv
module tri_bbox #(
  parameter int COORD_W  = 12,
  parameter int SCREEN_W = 64,
  parameter int SCREEN_H = 32,
  parameter int TXW      = 4,
  parameter int TYW      = 4
) (
  input  logic signed [COORD_W-1:0] x0,
  input  logic signed [COORD_W-1:0] y0,
  input  logic signed [COORD_W-1:0] x1,
  input  logic signed [COORD_W-1:0] y1,
  input  logic signed [COORD_W-1:0] x2,
  input  logic signed [COORD_W-1:0] y2,
  output logic                      offscreen,
  output logic [TXW-1:0]            tx_lo,
  output logic [TXW-1:0]            tx_hi,
  output logic [TYW-1:0]            ty_lo,
  output logic [TYW-1:0]            ty_hi
);
  import tri_dist_pkg::*;

  localparam logic signed [COORD_W-1:0] XMAX = COORD_W'(SCREEN_W - 1);
  localparam logic signed [COORD_W-1:0] YMAX = COORD_W'(SCREEN_H - 1);
  localparam logic signed [COORD_W-1:0] ZERO = '0;

  logic signed [COORD_W-1:0] min_x, max_x, min_y, max_y;
  logic signed [COORD_W-1:0] cl_x_lo, cl_x_hi, cl_y_lo, cl_y_hi;

  function automatic logic signed [COORD_W-1:0] smin(input logic signed [COORD_W-1:0] a,
                                                     input logic signed [COORD_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic signed [COORD_W-1:0] smax(input logic signed [COORD_W-1:0] a,
                                                     input logic signed [COORD_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    min_x = smin(smin(x0, x1), x2);
    max_x = smax(smax(x0, x1), x2);
    min_y = smin(smin(y0, y1), y2);
    max_y = smax(smax(y0, y1), y2);

    offscreen = (max_x < ZERO) || (max_y < ZERO) || (min_x > XMAX) || (min_y > YMAX);

    // clip to the visible area
    cl_x_lo = smax(min_x, ZERO);
    cl_x_hi = smin(max_x, XMAX);
    cl_y_lo = smax(min_y, ZERO);
    cl_y_hi = smin(max_y, YMAX);

    tx_lo = TXW'(cl_x_lo >>> TILE_W_LOG);
    tx_hi = TXW'(cl_x_hi >>> TILE_W_LOG);
    ty_lo = TYW'(cl_y_lo >>> TILE_H_LOG);
    ty_hi = TYW'(cl_y_hi >>> TILE_H_LOG);
  end
endmodule

// File: rtl/tri_owner_map.sv
module tri_owner_map #(
  parameter int TXW = 4,
  parameter int TYW = 4
) (
  input  logic [TXW-1:0] tx_lo,
  input  logic [TXW-1:0] tx_hi,
  input  logic [TYW-1:0] ty_lo,
  input  logic [TYW-1:0] ty_hi,
  output logic [3:0]     owners
);
  import tri_dist_pkg::*;

  logic [1:0]     x_par;   // tile-column parities touched
  logic [3:0]     y_mod;   // tile-row values mod 4 touched
  logic [TYW:0]   row;

  always_comb begin
    if (tx_hi != tx_lo) x_par = 2'b11;
    else                x_par = tx_lo[0] ? 2'b10 : 2'b01;

    // at most four rows matter, since ownership repeats every 4 rows
    y_mod = '0;
    row   = '0;
    for (int k = 0; k < 4; k++) begin
      row = {1'b0, ty_lo} + (TYW + 1)'(k);
      if (row <= {1'b0, ty_hi}) y_mod[row[1:0]] = 1'b1;
    end

    owners = '0;
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < 2; c++) begin
        if (y_mod[r] && x_par[c]) begin
          owners[tile_owner(c[0], r[0], r[1])] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tri_queue.sv
module tri_queue #(
  parameter int W     = 80,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          pop;

  assign pop   = valid && ready;
  assign valid = (count != '0);
  assign full  = (count == (AW + 1)'(DEPTH));
  assign dout  = store[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/tri_tile_distributor.sv
module tri_tile_distributor #(
  parameter int COORD_W  = 12,
  parameter int SEQ_W    = 8,
  parameter int SCREEN_W = 64,
  parameter int SCREEN_H = 32,
  parameter int Q_DEPTH  = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [SEQ_W-1:0]                         in_seq,
  input  logic [COORD_W-1:0]                       in_x0,
  input  logic [COORD_W-1:0]                       in_y0,
  input  logic [COORD_W-1:0]                       in_x1,
  input  logic [COORD_W-1:0]                       in_y1,
  input  logic [COORD_W-1:0]                       in_x2,
  input  logic [COORD_W-1:0]                       in_y2,
  output logic [3:0]                               out_valid,
  input  logic [3:0]                               out_ready,
  output logic [3:0][SEQ_W+6*COORD_W-1:0]          out_tri
);
  import tri_dist_pkg::*;

  localparam int TRI_W = SEQ_W + 6 * COORD_W;
  localparam int TXW   = $clog2(SCREEN_W >> TILE_W_LOG);
  localparam int TYW   = $clog2(SCREEN_H >> TILE_H_LOG);

  logic                 offscreen;
  logic [TXW-1:0]       tx_lo, tx_hi;
  logic [TYW-1:0]       ty_lo, ty_hi;
  logic [3:0]           owners, sel, q_full, push;
  logic                 accept;
  logic [TRI_W-1:0]     packed_tri;

  tri_bbox #(
    .COORD_W(COORD_W), .SCREEN_W(SCREEN_W), .SCREEN_H(SCREEN_H),
    .TXW(TXW), .TYW(TYW)
  ) u_bbox (
    .x0(in_x0), .y0(in_y0), .x1(in_x1), .y1(in_y1), .x2(in_x2), .y2(in_y2),
    .offscreen(offscreen),
    .tx_lo(tx_lo), .tx_hi(tx_hi), .ty_lo(ty_lo), .ty_hi(ty_hi)
  );

  tri_owner_map #(.TXW(TXW), .TYW(TYW)) u_owner (
    .tx_lo(tx_lo), .tx_hi(tx_hi), .ty_lo(ty_lo), .ty_hi(ty_hi),
    .owners(owners)
  );

  assign sel        = offscreen ? 4'b0000 : owners;
  assign in_ready   = ~|(sel & q_full);
  assign accept     = in_valid && in_ready;
  assign push       = accept ? sel : 4'b0000;
  assign packed_tri = {in_seq, in_x0, in_y0, in_x1, in_y1, in_x2, in_y2};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    tri_queue #(.W(TRI_W), .DEPTH(Q_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(push[u]), .din(packed_tri), .full(q_full[u]),
      .valid(out_valid[u]), .ready(out_ready[u]), .dout(out_tri[u])
    );

    // R8
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[u] && !out_ready[u]) |=> (out_valid[u] && $stable(out_tri[u])));
  end

  // R3
  onscreen_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !offscreen) |-> (owners != 4'b0000));

  // R4
  offscreen_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && offscreen) |-> in_ready);

  // R5
  clip_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !offscreen) |-> ((tx_lo <= tx_hi) && (ty_lo <= ty_hi)));

  // R10
  big_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !offscreen && ((tx_hi - tx_lo) >= TXW'(3)) && ((ty_hi - ty_lo) >= TYW'(3)))
      |-> (owners == 4'b1111));
endmodule

// File: tb/test_tri_tile_distributor.sv
module test_tri_tile_distributor;
  localparam int CW = 12;
  localparam int SW = 8;
  localparam int SCR_W = 64;
  localparam int SCR_H = 32;
  localparam int TW = SW + 6 * CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [SW-1:0] in_seq = '0;
  logic [CW-1:0] in_x0 = '0, in_y0 = '0, in_x1 = '0, in_y1 = '0, in_x2 = '0, in_y2 = '0;
  logic [3:0] out_valid;
  logic [3:0] out_ready = 4'b0000;
  logic [3:0][TW-1:0] out_tri;

  always #2 clk = ~clk;  // 250 MHz

  tri_tile_distributor #(.COORD_W(CW), .SEQ_W(SW), .SCREEN_W(SCR_W), .SCREEN_H(SCR_H),
                         .Q_DEPTH(4)) i_tri_tile_distributor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_seq(in_seq),
    .in_x0(in_x0), .in_y0(in_y0), .in_x1(in_x1), .in_y1(in_y1), .in_x2(in_x2), .in_y2(in_y2),
    .out_valid(out_valid), .out_ready(out_ready), .out_tri(out_tri));

  int checks = 0;
  int fails = 0;
  logic [TW-1:0] q0[$], q1[$], q2[$], q3[$];
  logic [3:0] rcv_mask [256];
  logic [3:0] hold = 4'b0000;
  bit rand_ready = 1'b0;
  bit sending = 1'b0;
  bit running = 1'b0;
  int seq_ctr = 0;
  int last_seq = 0;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_mask(input int x0, input int y0, input int x1,
                                            input int y1, input int x2, input int y2);
    int lx, hx, ly, hy;
    logic [3:0] m;
    lx = (x0 < x1) ? x0 : x1; lx = (x2 < lx) ? x2 : lx;
    hx = (x0 > x1) ? x0 : x1; hx = (x2 > hx) ? x2 : hx;
    ly = (y0 < y1) ? y0 : y1; ly = (y2 < ly) ? y2 : ly;
    hy = (y0 > y1) ? y0 : y1; hy = (y2 > hy) ? y2 : hy;
    m = 4'b0000;
    if (hx < 0 || hy < 0 || lx > SCR_W - 1 || ly > SCR_H - 1) return m;
    if (lx < 0) lx = 0;
    if (ly < 0) ly = 0;
    if (hx > SCR_W - 1) hx = SCR_W - 1;
    if (hy > SCR_H - 1) hy = SCR_H - 1;
    for (int tx = lx / 4; tx <= hx / 4; tx++)
      for (int ty = ly / 2; ty <= hy / 2; ty++)
        m[((tx & 1) ^ (ty & 1)) + 2 * ((ty >> 1) & 1)] = 1'b1;
    return m;
  endfunction

  task automatic send(input int x0, input int y0, input int x1, input int y1,
                      input int x2, input int y2);
    logic [TW-1:0] p;
    logic [3:0] m;
    logic [SW-1:0] s;
    sending = 1'b1;
    s = SW'(seq_ctr);
    seq_ctr++;
    last_seq = int'(s);
    rcv_mask[s] = 4'b0000;
    p = {s, CW'(x0), CW'(y0), CW'(x1), CW'(y1), CW'(x2), CW'(y2)};
    m = model_mask(x0, y0, x1, y1, x2, y2);
    if (m[0]) q0.push_back(p);
    if (m[1]) q1.push_back(p);
    if (m[2]) q2.push_back(p);
    if (m[3]) q3.push_back(p);
    @(negedge clk);
    in_valid = 1'b1; in_seq = s;
    in_x0 = CW'(x0); in_y0 = CW'(y0); in_x1 = CW'(x1);
    in_y1 = CW'(y1); in_x2 = CW'(x2); in_y2 = CW'(y2);
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    sending = 1'b0;
  endtask

  function automatic int pending();
    return q0.size() + q1.size() + q2.size() + q3.size();
  endfunction

  task automatic drain();
    int n = 0;
    while ((pending() != 0 || out_valid != 4'b0000) && n < 400) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_mask(input int x0, input int y0, input int x1, input int y1,
                             input int x2, input int y2, input logic [3:0] exp,
                             input string req);
    send(x0, y0, x1, y1, x2, y2);
    drain();
    check(rcv_mask[last_seq] == exp, req, 128'(rcv_mask[last_seq]), 128'(exp));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (running) begin
      for (int u = 0; u < 4; u++)
        out_ready[u] = hold[u] ? 1'b0 : (rand_ready ? 1'($urandom_range(0, 1)) : 1'b1);
      for (int u = 0; u < 4; u++) begin
        if (out_valid[u] && out_ready[u]) begin
          logic [TW-1:0] e;
          bit have;
          have = 1'b0;
          e = '0;
          case (u)
            0: if (q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
            1: if (q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
            2: if (q2.size() > 0) begin e = q2.pop_front(); have = 1'b1; end
            default: if (q3.size() > 0) begin e = q3.pop_front(); have = 1'b1; end
          endcase
          rcv_mask[out_tri[u][TW-1 -: SW]][u] = 1'b1;
          // R3: no copy to a unit that owns none of the tiles
          check(have, "R3 unexpected copy", 128'(out_tri[u]), 128'(u));
          // R7: content and per-queue order
          if (have) check(out_tri[u] == e, "R7 copy content/order", 128'(out_tri[u]), 128'(e));
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [TW-1:0] held;
    for (int i = 0; i < 256; i++) rcv_mask[i] = 4'b0000;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(out_valid == 4'b0000, "R9 out_valid after reset", 128'(out_valid), 0);
    check(in_ready == 1'b1, "R9 in_ready after reset", 128'(in_ready), 1);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // R1/R2: single-tile triangles, one per unit
    expect_mask(1, 1, 2, 0, 3, 1, 4'b0001, "R1 R2 tile(0,0)");
    expect_mask(5, 0, 6, 1, 4, 1, 4'b0010, "R2 tile(1,0)");
    expect_mask(1, 4, 2, 5, 0, 5, 4'b0100, "R2 tile(0,2)");
    expect_mask(1, 6, 2, 7, 0, 7, 4'b1000, "R2 tile(0,3)");
    // R11: small triangles on tile edges
    expect_mask(3, 0, 4, 0, 4, 1, 4'b0011, "R11 straddle x edge");
    expect_mask(0, 3, 1, 4, 2, 4, 4'b0110, "R11 straddle y edge");
    // R10: large box
    expect_mask(0, 0, 20, 0, 0, 10, 4'b1111, "R10 large box");
    // R5: clipping at both edges
    expect_mask(-50, -50, -40, -30, 1, 1, 4'b0001, "R5 clip low");
    expect_mask(63, 31, 200, 100, 150, 40, 4'b0100, "R5 clip high");
    // R4: off-screen drop
    expect_mask(-10, -5, -2, 3, -1, 0, 4'b0000, "R4 left of screen");
    expect_mask(70, 0, 80, 5, 90, 2, 4'b0000, "R4 right of screen");

    // R6/R8: atomic stall
    hold = 4'b1111;
    @(negedge clk);
    for (int i = 0; i < 4; i++) send(1, 1, 2, 0, 3, 1);
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 4'b0001, "R6 only unit0 filled", 128'(out_valid), 1);
    fork
      send(-30, -30, -20, -5, -9, -1);
    join_none
    repeat (2) @(negedge clk);
    check(sending == 1'b0, "R4 off-screen taken while full", 128'(sending), 0);
    held = out_tri[0];
    fork
      send(0, 0, 40, 0, 0, 20);
    join_none
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R6 in_ready low when queue full", 128'(in_ready), 0);
    check(out_valid[3:1] == 3'b000, "R6 no partial copy", 128'(out_valid[3:1]), 0);
    check(out_valid[0] && out_tri[0] == held, "R8 held output stable", 128'(out_tri[0]),
          128'(held));
    hold = 4'b0000;
    while (sending) @(negedge clk);
    drain();
    check(rcv_mask[last_seq] == 4'b1111, "R6 R10 copies after release",
          128'(rcv_mask[last_seq]), 128'hF);

    // R3/R7: random triangles with random back-pressure
    rand_ready = 1'b1;
    for (int i = 0; i < 80; i++) begin
      int bx, by;
      bx = $urandom_range(0, 100) - 20;
      by = $urandom_range(0, 50) - 10;
      send(bx + $urandom_range(0, 6), by + $urandom_range(0, 4),
           bx + $urandom_range(0, 12), by + $urandom_range(0, 8),
           bx + $urandom_range(0, 3), by + $urandom_range(0, 20));
    end
    rand_ready = 1'b0;
    drain();
    // R3: every expected copy arrived
    check(q0.size() == 0, "R3 unit0 missing copies", 128'(q0.size()), 0);
    check(q1.size() == 0, "R3 unit1 missing copies", 128'(q1.size()), 0);
    check(q2.size() == 0, "R3 unit2 missing copies", 128'(q2.size()), 0);
    check(q3.size() == 0, "R3 unit3 missing copies", 128'(q3.size()), 0);
    summary();
    $finish;
  end
endmodule